// File: doc/BRIEF.md
# Paged Audio Controller Register File

This block is the host-side register file of a three-channel audio controller with two playback channels and one capture channel. A host reaches it through a 64-byte I/O window. Each access can be a byte, a 16-bit half or a 32-bit word. The block holds the control, serial-control, codec, memory-page and sample-count registers. It also keeps the per-channel interrupt pending bits, which it folds into a summary status bit and a single level interrupt output.

The top 16 bytes of the window, offsets 0x30 to 0x3F, are a paged sub-window. The 4-bit memory page is OR-ed in above the window offset. Page 0xC reaches four frame words for the two playback channels, and page 0xD reaches four frame words for the capture channel and a spare pair. The channel engines are outside this block. They raise pending bits with one-cycle set strobes and push their live sample counts through an update port.

A small access controller arbitrates the host port. It has two states. `ACC_IDLE` accepts a request. Taking a read moves it to `ACC_RESP` (transition "read accepted"). `ACC_RESP` presents the read data for one cycle and always returns to `ACC_IDLE` (transition "response delivered"). A write completes in `ACC_IDLE` and leaves the state unchanged (transition "write absorbed").

Top module: `audio_regfile_top`

## Requirements
- R1: After reset every register and pending bit is zero, `irq_o` is low and `req_ready` is high.
- R2: A read accepted on a cycle with `req_valid` and `req_ready` high raises `rd_valid` for exactly one cycle on the following cycle, and `req_ready` is low during that cycle. A write accepted in the same way takes effect at that clock edge.
- R3: Access size is encoded in `req_size` as 0 = byte, 1 = 16-bit, 2 or 3 = 32-bit. Write data is right-justified. A byte write replaces lane `req_addr[1:0]` and a 16-bit write replaces the half chosen by `req_addr[1]`; all other bits are kept. A read returns the word shifted right by 8×`req_addr[1:0]`, masked to the access size.
- R4: The register map is control 0x00, status 0x04, memory page 0x0C, codec 0x10, serial control 0x20, and sample counts 0x24 (DAC1), 0x28 (DAC2) and 0x2C (ADC). The memory page keeps only bits 3:0.
- R5: At offsets 0x30 to 0x3F, page 0xC selects frame words 0 to 3 and page 0xD selects frame words 4 to 7, indexed by `req_addr[3:2]`. Each frame word is independent storage.
- R6: A write to a sample-count register changes only bits 15:0. Bits 31:16 take `cnt_live` when that channel's `cnt_live_we` bit is high. A 16-bit read at offset +2 returns that upper half.
- R7: Status is read-only. Status bits 2, 1 and 0 are the DAC1, DAC2 and ADC pending flags. Each flag is set by `ch_set` bit 2, 1 or 0, but only while that channel's interrupt enable is 1. The enables sit in serial control at bit 8 (DAC1), bit 9 (DAC2) and bit 10 (ADC).
- R8: Status bit 31 and `irq_o` are both 1 exactly when any pending flag is set.
- R9: A serial-control write that turns an enable from 1 to 0 clears that channel's pending flag. If a set strobe for the same channel arrives in the same cycle, the set wins.
- R10: Reads of unmapped offsets, and of the paged window under any page other than 0xC or 0xD, return zero. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte offset in the I/O window |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Right-justified write data |
| req_ready | output | 1 | Controller can take a request |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, right-justified |
| ch_set | input | 3 | Pending set strobes (bit 2 DAC1, bit 1 DAC2, bit 0 ADC) |
| cnt_live_we | input | 3 | Live count update strobes (same bit order) |
| cnt_live | input | 48 | Live counts, channel c in bits 16c+15:16c |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench covers these corner cases:

- **Partial-lane merges.** A wrong lane mask would clobber neighbouring bytes of control, and that shows up in word reads after byte and half writes.
- **Page aliasing.** The same window offset is written under page 0xC and page 0xD, then read back under both. A decoder that ignores the page returns the last value written, and one that keeps more than four page bits misses the window.
- **Upper-half protection of the sample counts.** A host write that leaks into the live count, or a live update that is lost, corrupts a word or +2 read.
- **Interrupt enables.** The bench sets a flag with its enable off, writes the read-only status, and drops an enable with and without a coincident set strobe. A design that clears on a level instead of a falling edge, or that lets the clear win, leaves the wrong pending bits and the wrong `irq_o`.

// File: rtl/arf_pkg.sv
package arf_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_e;

    // byte-lane enables for an access of size sz at byte offset off
    function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
        logic [3:0] m;
        unique case (acc_size_e'(sz))
            SZ_BYTE: m = 4'b0001 << off;
            SZ_HALF: m = off[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

    // move right-justified write data to its lane position
    function automatic logic [31:0] align_wdata(input logic [1:0] sz, input logic [1:0] off,
                                                input logic [31:0] d);
        logic [31:0] r;
        unique case (acc_size_e'(sz))
            SZ_BYTE: r = d << {off, 3'b000};
            SZ_HALF: r = d << {off[1], 4'b0000};
            default: r = d;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] merge_lanes(input logic [31:0] old_w, input logic [31:0] new_w,
                                                input logic [3:0] m);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) begin
            r[i*8 +: 8] = m[i] ? new_w[i*8 +: 8] : old_w[i*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [31:0] extract_read(input logic [1:0] sz, input logic [1:0] off,
                                                 input logic [31:0] w);
        logic [31:0] s;
        s = w >> {off, 3'b000};
        unique case (acc_size_e'(sz))
            SZ_BYTE: s = s & 32'h0000_00FF;
            SZ_HALF: s = s & 32'h0000_FFFF;
            default: s = s;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/arf_access_ctl.sv
module arf_access_ctl
    import arf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] rd_word,
    output logic        req_ready,
    output logic        wr_fire,
    output logic        rd_valid,
    output logic [31:0] rd_data
);
    acc_state_e state_q, state_d;
    logic       rd_fire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        rd_valid  = 1'b0;
        wr_fire   = 1'b0;
        rd_fire   = 1'b0;
        unique case (state_q)
            ACC_IDLE: begin
                req_ready = 1'b1;
                if (req_valid && req_write) wr_fire = 1'b1;
                if (req_valid && !req_write) begin
                    rd_fire = 1'b1;
                    state_d = ACC_RESP;
                end
            end
            ACC_RESP: begin
                rd_valid = 1'b1;
                state_d  = ACC_IDLE;
            end
            default: state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_data <= '0;
        else if (rd_fire) rd_data <= rd_word;
    end

    AST_RESP_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);                                          // R2
    AST_READ_GIVES_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> (rd_valid && !req_ready)); // R2
endmodule

// File: rtl/arf_irq_agg.sv
module arf_irq_agg #(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_set,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] en_drop,
    output logic [NUM_CH-1:0] pending,
    output logic              irq
);
    logic [NUM_CH-1:0] take;

    assign take = ch_set & ch_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pending <= '0;
        else        pending <= (pending & ~en_drop) | take;
    end

    assign irq = |pending;

    AST_SET_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (take != '0) |=> ((pending & $past(take)) == $past(take)));                // R7
    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_drop & ~take) != '0) |=> ((pending & $past(en_drop & ~take)) == '0)); // R9
endmodule

// File: rtl/arf_frame_bank.sv
module arf_frame_bank
    import arf_pkg::*;
#(
    parameter int          PAGE_W      = 4,
    parameter int          FRAME_PAGES = 2,
    parameter logic [3:0]  PAGE_BASE   = 4'hC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] page,
    input  logic              in_window,
    input  logic [1:0]        slot,
    input  logic              wr_en,
    input  logic [3:0]        wmask,
    input  logic [31:0]       wdata,
    output logic              hit,
    output logic [31:0]       rd_word
);
    localparam int SLOTS   = 4;
    localparam int ENTRIES = FRAME_PAGES * SLOTS;

    logic [31:0]        mem_q [ENTRIES];
    logic [ENTRIES-1:0] sel;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        localparam logic [PAGE_W-1:0] MY_PAGE = PAGE_W'(PAGE_BASE) + PAGE_W'(e / SLOTS);
        localparam logic [1:0]        MY_SLOT = 2'(e % SLOTS);
        assign sel[e] = in_window && (page == MY_PAGE) && (slot == MY_SLOT);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              mem_q[e] <= '0;
            else if (wr_en && sel[e]) mem_q[e] <= merge_lanes(mem_q[e], wdata, wmask);
        end
    end

    always_comb begin
        rd_word = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (sel[e]) rd_word = mem_q[e];
        end
    end

    assign hit = |sel;

    AST_ONE_FRAME_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));                                                    // R5
endmodule

// File: rtl/audio_regfile_top.sv
module audio_regfile_top
    import arf_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter int CNT_W   = 16,
    parameter int PAGE_W  = 4,
    parameter int IEN_LSB = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [5:0]              req_addr,
    input  logic [1:0]              req_size,
    input  logic [31:0]             req_wdata,
    output logic                    req_ready,
    output logic                    rd_valid,
    output logic [31:0]             rd_data,
    input  logic [NUM_CH-1:0]       ch_set,
    input  logic [NUM_CH-1:0]       cnt_live_we,
    input  logic [NUM_CH*CNT_W-1:0] cnt_live,
    output logic                    irq_o
);
    localparam logic [3:0] W_CTRL  = 4'd0;
    localparam logic [3:0] W_STAT  = 4'd1;
    localparam logic [3:0] W_PAGE  = 4'd3;
    localparam logic [3:0] W_CODEC = 4'd4;
    localparam logic [3:0] W_SCTL  = 4'd8;
    localparam logic [3:0] W_SCNT_TOP = 4'd11;   // channel c at word 11 - c
    localparam logic [3:0] LOW_HALF = 4'b0011;

    logic [31:0]       ctrl_q, sctl_q, codec_q;
    logic [PAGE_W-1:0] page_q;
    logic [CNT_W-1:0]  cnt_lo_q [NUM_CH];
    logic [CNT_W-1:0]  cnt_hi_q [NUM_CH];
    logic [NUM_CH-1:0] pending, ch_en, en_drop;
    logic              wr_fire, irq_int;
    logic [3:0]        word_idx, wmask;
    logic [1:0]        off;
    logic [31:0]       wal, sctl_next, word_sel, rd_word, frame_word, status_word;
    logic              in_window, frame_hit;

    assign off       = req_addr[1:0];
    assign word_idx  = req_addr[5:2];
    assign in_window = (req_addr[5:4] == 2'b11);
    assign wmask     = lane_mask(req_size, off);
    assign wal       = align_wdata(req_size, off, req_wdata);
    assign sctl_next = merge_lanes(sctl_q, wal, wmask);

    arf_access_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .rd_word(rd_word), .req_ready(req_ready), .wr_fire(wr_fire),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // plain storage registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            sctl_q  <= '0;
            codec_q <= '0;
            page_q  <= '0;
        end else if (wr_fire && !in_window) begin
            if (word_idx == W_CTRL)  ctrl_q  <= merge_lanes(ctrl_q, wal, wmask);
            if (word_idx == W_SCTL)  sctl_q  <= sctl_next;
            if (word_idx == W_CODEC) codec_q <= merge_lanes(codec_q, wal, wmask);
            if (word_idx == W_PAGE && wmask[0]) page_q <= wal[PAGE_W-1:0];
        end
    end

    // sample counts: host owns the low half, engines own the high half
    for (genvar c = 0; c < NUM_CH; c++) begin : g_cnt
        localparam logic [3:0] MY_WORD = W_SCNT_TOP - 4'(c);
        logic [31:0] merged;
        assign merged = merge_lanes({cnt_hi_q[c], cnt_lo_q[c]}, wal, wmask & LOW_HALF);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_lo_q[c] <= '0;
                cnt_hi_q[c] <= '0;
            end else begin
                if (wr_fire && !in_window && word_idx == MY_WORD)
                    cnt_lo_q[c] <= merged[CNT_W-1:0];
                if (cnt_live_we[c])
                    cnt_hi_q[c] <= cnt_live[c*CNT_W +: CNT_W];
            end
        end
        assign ch_en[c]   = sctl_q[IEN_LSB + NUM_CH - 1 - c];
        assign en_drop[c] = wr_fire && !in_window && (word_idx == W_SCTL)
                            && sctl_q[IEN_LSB + NUM_CH - 1 - c]
                            && !sctl_next[IEN_LSB + NUM_CH - 1 - c];
    end

    arf_irq_agg #(.NUM_CH(NUM_CH)) u_irq (
        .clk(clk), .rst_n(rst_n), .ch_set(ch_set), .ch_en(ch_en),
        .en_drop(en_drop), .pending(pending), .irq(irq_int)
    );

    arf_frame_bank #(.PAGE_W(PAGE_W)) u_frames (
        .clk(clk), .rst_n(rst_n), .page(page_q), .in_window(in_window),
        .slot(req_addr[3:2]), .wr_en(wr_fire), .wmask(wmask), .wdata(wal),
        .hit(frame_hit), .rd_word(frame_word)
    );

    assign status_word = {irq_int, {(31-NUM_CH){1'b0}}, pending};
    assign irq_o       = irq_int;

    always_comb begin
        word_sel = '0;
        if (in_window) begin
            if (frame_hit) word_sel = frame_word;
        end else begin
            unique case (word_idx)
                W_CTRL:  word_sel = ctrl_q;
                W_STAT:  word_sel = status_word;
                W_PAGE:  word_sel = 32'(page_q);
                W_CODEC: word_sel = codec_q;
                W_SCTL:  word_sel = sctl_q;
                default: begin
                    for (int c = 0; c < NUM_CH; c++) begin
                        if (word_idx == W_SCNT_TOP - 4'(c))
                            word_sel = {cnt_hi_q[c], cnt_lo_q[c]};
                    end
                end
            endcase
        end
    end

    assign rd_word = extract_read(req_size, off, word_sel);

    AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !in_window && word_idx == W_STAT && ch_set == '0)
        |=> (pending == $past(pending)));                                  // R7
    AST_IRQ_MEANS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (status_word[NUM_CH-1:0] != '0));                         // R8
    AST_HOST_KEEPS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_live_we == '0) |=> (cnt_hi_q[0] == $past(cnt_hi_q[0])));      // R6
endmodule

// File: tb/audio_regfile_top_test.sv
module audio_regfile_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rd_valid, irq_o;
    logic [31:0] rd_data;
    logic [2:0]  ch_set = '0, cnt_live_we = '0;
    logic [47:0] cnt_live = '0;

    int n_tests = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    audio_regfile_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .ch_set(ch_set), .cnt_live_we(cnt_live_we), .cnt_live(cnt_live), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) check("R2 unexpected response", 32'h1, 32'h0);
            else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    task automatic wr(input logic [5:0] a, input logic [1:0] sz, input logic [31:0] d,
                      input logic [2:0] set = 3'b000);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
        ch_set = set;
        @(negedge clk);
        req_valid = 1'b0; ch_set = '0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [1:0] sz, input logic [31:0] exp,
                      input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 ready low while responding", {31'b0, req_ready}, 32'h0);
        @(negedge clk);
    endtask

    task automatic strobe(input logic [2:0] s);
        @(negedge clk); ch_set = s;
        @(negedge clk); ch_set = '0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check("watchdog expired", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
        check("R1 ready after reset", {31'b0, req_ready}, 32'h1);
        rd(6'h00, 2'd2, 32'h0, "R1 control reset");
        rd(6'h04, 2'd2, 32'h0, "R1 status reset");
        // R3 lane merges
        wr(6'h02, 2'd0, 32'hFFFF_FFAB);
        rd(6'h00, 2'd2, 32'h00AB_0000, "R3 byte lane 2 write");
        wr(6'h02, 2'd1, 32'h0000_1234);
        wr(6'h00, 2'd0, 32'h0000_005A);
        rd(6'h00, 2'd2, 32'h1234_005A, "R3 half and byte merge");
        rd(6'h03, 2'd0, 32'h0000_0012, "R3 byte read lane 3");
        rd(6'h00, 2'd1, 32'h0000_005A, "R3 half read low");
        wr(6'h10, 2'd2, 32'h0000_A55A);
        rd(6'h10, 2'd2, 32'h0000_A55A, "R4 codec storage");
        // R4 page width, R10 dead page
        wr(6'h0C, 2'd2, 32'hFFFF_FFF7);
        rd(6'h0C, 2'd2, 32'h0000_0007, "R4 page keeps 4 bits");
        wr(6'h30, 2'd2, 32'h1111_1111);
        rd(6'h30, 2'd2, 32'h0, "R10 window on unmapped page");
        // R5 paging
        wr(6'h0C, 2'd0, 32'h0C);
        wr(6'h34, 2'd2, 32'hCAFE_0001);
        wr(6'h0C, 2'd0, 32'h0D);
        wr(6'h34, 2'd2, 32'hBEEF_0002);
        rd(6'h34, 2'd2, 32'hBEEF_0002, "R5 page D slot 1");
        wr(6'h0C, 2'd0, 32'h0C);
        rd(6'h34, 2'd2, 32'hCAFE_0001, "R5 page C slot 1");
        rd(6'h38, 2'd2, 32'h0, "R5 page C slot 2 untouched");
        rd(6'h30, 2'd2, 32'h0, "R10 dead-page write had no effect");
        // R6 sample counts (0x24 = channel bit 2)
        wr(6'h24, 2'd2, 32'hDEAD_BEEF);
        rd(6'h24, 2'd2, 32'h0000_BEEF, "R6 host write low half only");
        @(negedge clk); cnt_live = 48'h0055_0000_0000; cnt_live_we = 3'b100;
        @(negedge clk); cnt_live_we = '0;
        rd(6'h24, 2'd2, 32'h0055_BEEF, "R6 live count word");
        rd(6'h26, 2'd1, 32'h0000_0055, "R6 live count half +2");
        rd(6'h2C, 2'd2, 32'h0, "R6 other channel untouched");
        // R7 gating, R8 summary
        strobe(3'b100);
        rd(6'h04, 2'd2, 32'h0, "R7 set ignored while disabled");
        wr(6'h20, 2'd2, 32'h0000_0700);
        strobe(3'b100);
        rd(6'h04, 2'd2, 32'h8000_0004, "R8 status summary DAC1");
        check("R8 irq high", {31'b0, irq_o}, 32'h1);
        wr(6'h04, 2'd2, 32'h0);
        rd(6'h04, 2'd2, 32'h8000_0004, "R7 status write ignored");
        // R9 drop clears
        wr(6'h21, 2'd0, 32'h06);
        rd(6'h04, 2'd2, 32'h0, "R9 DAC1 drop clears");
        check("R8 irq low", {31'b0, irq_o}, 32'h0);
        strobe(3'b011);
        rd(6'h04, 2'd2, 32'h8000_0003, "R7 DAC2 and ADC set");
        wr(6'h21, 2'd0, 32'h02, 3'b001);
        rd(6'h04, 2'd2, 32'h8000_0003, "R9 set wins over drop");
        wr(6'h21, 2'd0, 32'h00);
        rd(6'h04, 2'd2, 32'h8000_0001, "R9 DAC2 drop, ADC kept");
        check("R8 irq still high", {31'b0, irq_o}, 32'h1);
        // R10 unmapped
        wr(6'h14, 2'd2, 32'h1234_5678);
        rd(6'h14, 2'd2, 32'h0, "R10 unmapped reads zero");
        rd(6'h00, 2'd2, 32'h1234_005A, "R10 unmapped write left control");
        repeat (3) @(negedge clk);
        check("R2 all responses seen", 32'(exp_q.size()), 32'h0);
        finish_run();
    end
endmodule